// File: doc/BRIEF.md
# Interrupt Delay Coalescer

This block moderates interrupts for one group of ring completions. Eight one-cycle strobes come in, one from each of four receive rings and four transmit rings. A bitmap in the 32-bit configuration word chooses which rings feed the group. Each cycle, the block adds the number of selected strobes to a saturating event counter. It raises one interrupt request when either of two conditions is met first:

- the count reaches a programmed threshold;
- a programmed number of timebase ticks has passed while events are pending.

The request stays high until the interrupt handler acknowledges it. Firing clears the counter and the timer. A chip that needs two groups instantiates this block twice, each with its own configuration word of the same layout. The tick usually comes from a 10 µs timebase outside the block.

All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, `irq` is low, the event count is zero and the delay timer is zero.
- R2: Bit 28+i of `cfg_word` enables receive strobe `rx_done[i]`, and bit 24+i enables transmit strobe `tx_done[i]`, for i = 0..3. A strobe whose enable bit is clear has no effect on the count.
- R3: The count increases by the number of enabled strobes that are high in a cycle, which can be up to 8. It saturates at 31 and does not wrap.
- R4: Bits 20:16 of `cfg_word` hold the count threshold. If the threshold is nonzero and the updated count at a clock edge is greater than or equal to it, `irq` is high from that edge on. A threshold of zero disables this trigger.
- R5: Bits 10:0 of `cfg_word` hold the maximum delay in ticks. The timer advances on each `tick` seen at an edge where the count was already nonzero before that edge. A tick in the same cycle as the first event is not counted. If the delay is nonzero and the timer reaches it, `irq` is high from that edge on. A delay of zero disables this trigger.
- R6: When `irq` fires, the count and the timer are cleared. `irq` stays high until an edge at which `ack` is high, and it is low after that edge.
- R7: While `irq` is high, strobes and ticks are ignored, so the count after an acknowledge starts from zero. An `ack` while `irq` is low has no effect and keeps the pending count.
- R8: The threshold and the delay are compared live against `cfg_word`. If the threshold is raised or lowered onto a count that is already held, the block fires at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Source bitmap, count threshold and maximum delay |
| rx_done | input | 4 | Receive ring completion strobes, bit i for ring i |
| tx_done | input | 4 | Transmit ring completion strobes, bit i for ring i |
| tick | input | 1 | Timebase tick, one cycle per delay unit |
| ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Coalesced interrupt request |

## Verification
Single enabled strobes that climb to the threshold separate the count trigger from the timeout. A burst of all eight strobes in one cycle shows that simultaneous events add rather than being counted as one. A map that enables one ring while the other seven toggle tells the selected ring apart from the ignored ones. Ticks that arrive with and without pending events, including one in the same cycle as the first event, fix the cycle at which the timer starts. Pumping forty events with both triggers off and then raising the threshold to 31 tells saturation apart from wrap-around. Randomly varied masks, thresholds, delays, tick density and acknowledge timing are then checked cycle by cycle against a reference model in the bench.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

  localparam int CFG_W      = 32;
  localparam int RINGS      = 4;
  localparam int RX_EN_LSB  = 28;
  localparam int TX_EN_LSB  = 24;
  localparam int THR_LSB    = 16;
  localparam int THR_W      = 5;
  localparam int DLY_LSB    = 0;
  localparam int DLY_W      = 11;

  typedef struct packed {
    logic [RINGS-1:0] rx_en;
    logic [RINGS-1:0] tx_en;
    logic [THR_W-1:0] thresh;
    logic [DLY_W-1:0] max_dly;
  } coal_cfg_t;

  function automatic coal_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    coal_cfg_t c;
    c.rx_en   = w[RX_EN_LSB +: RINGS];
    c.tx_en   = w[TX_EN_LSB +: RINGS];
    c.thresh  = w[THR_LSB +: THR_W];
    c.max_dly = w[DLY_LSB +: DLY_W];
    return c;
  endfunction

endpackage

// File: rtl/irq_src_select.sv
module irq_src_select #(
  parameter int RINGS = 4,
  localparam int SRCS  = 2 * RINGS,
  localparam int HIT_W = $clog2(SRCS + 1)
) (
  input  logic [RINGS-1:0] rx_done,
  input  logic [RINGS-1:0] tx_done,
  input  logic [RINGS-1:0] rx_en,
  input  logic [RINGS-1:0] tx_en,
  output logic [HIT_W-1:0] hits
);

  logic [SRCS-1:0] gated;

  // Lower half of the vector: transmit rings; upper half: receive rings.
  for (genvar g = 0; g < RINGS; g++) begin : g_gate
    assign gated[g]         = tx_done[g] & tx_en[g];
    assign gated[RINGS + g] = rx_done[g] & rx_en[g];
  end

  always_comb begin
    hits = '0;
    for (int i = 0; i < SRCS; i++) begin
      hits = hits + HIT_W'(gated[i]);
    end
  end

endmodule

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
  parameter int CNT_W = 5,
  parameter int ADD_W = 4,
  localparam int SUM_W = ((CNT_W > ADD_W) ? CNT_W : ADD_W) + 1,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             clr,
  input  logic [ADD_W-1:0] add,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(count) + SUM_W'(add);
    if (hold) begin
      count_nxt = count;
    end else if (sum > SUM_W'(CNT_MAX)) begin
      count_nxt = CNT_MAX;
    end else begin
      count_nxt = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
    end else begin
      count <= count_nxt;
    end
  end

endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int DLY_W = 11,
  localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  output logic [DLY_W-1:0] value,
  output logic [DLY_W-1:0] value_nxt
);

  always_comb begin
    if (!hold && run && tick && value != DLY_MAX) begin
      value_nxt = value + 1'b1;
    end else begin
      value_nxt = value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      value <= '0;
    end else begin
      value <= value_nxt;
    end
  end

endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
  import irq_coal_pkg::*;
#(
  parameter int NRINGS = RINGS,
  localparam int HIT_W = $clog2(2 * NRINGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [NRINGS-1:0] rx_done,
  input  logic [NRINGS-1:0] tx_done,
  input  logic              tick,
  input  logic              ack,
  output logic              irq
);

  coal_cfg_t        cfg;
  logic [HIT_W-1:0] hits;
  logic [THR_W-1:0] evt_count;
  logic [THR_W-1:0] evt_count_nxt;
  logic [DLY_W-1:0] timer_val;
  logic [DLY_W-1:0] timer_nxt;
  logic             pending;
  logic             hit_thresh;
  logic             hit_delay;
  logic             fire;
  logic             irq_q;

  assign cfg     = unpack_cfg(cfg_word);
  assign pending = (evt_count != '0);

  irq_src_select #(.RINGS(NRINGS)) u_sel (
    .rx_done (rx_done),
    .tx_done (tx_done),
    .rx_en   (cfg.rx_en[NRINGS-1:0]),
    .tx_en   (cfg.tx_en[NRINGS-1:0]),
    .hits    (hits)
  );

  irq_evt_counter #(.CNT_W(THR_W), .ADD_W(HIT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (irq_q),
    .clr       (fire),
    .add       (hits),
    .count     (evt_count),
    .count_nxt (evt_count_nxt)
  );

  irq_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (irq_q),
    .clr       (fire),
    .run       (pending),
    .tick      (tick),
    .value     (timer_val),
    .value_nxt (timer_nxt)
  );

  always_comb begin
    hit_thresh = (cfg.thresh != '0) && (evt_count_nxt >= cfg.thresh);
    hit_delay  = (cfg.max_dly != '0) && pending && tick &&
                 (timer_nxt >= cfg.max_dly);
    fire       = !irq_q && (hit_thresh || hit_delay);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (fire) begin
      irq_q <= 1'b1;
    end else if (irq_q && ack) begin
      irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_coalescer_checker.sv
module irq_coalescer_checker #(
  parameter int CNT_W = 5,
  parameter int DLY_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cfg_word,
  input logic [3:0]       rx_done,
  input logic [3:0]       tx_done,
  input logic             ack,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [DLY_W-1:0] tmr
);

  logic [CNT_W-1:0] thr;
  logic [7:0]       live;
  assign thr  = cfg_word[16 +: CNT_W];
  assign live = {rx_done & cfg_word[31:28], tx_done & cfg_word[27:24]};

  // R6: request held until acknowledged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);

  // R6: acknowledge releases the request
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> !irq);

  // R7: nothing accumulates while the request is up
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0 && tmr == '0));

  // R4: with a steady nonzero threshold the held count stays below it
  a_r4_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0 && $stable(thr)) |-> (cnt < thr));

  // R2: with no enabled strobe the count either stays or is cleared by firing
  a_r2_no_enabled_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 8'd0) |=> (cnt == $past(cnt) || cnt == '0));

  // R5: timer only holds ticks while events are pending
  a_r5_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (tmr == '0));

endmodule

bind irq_coalescer irq_coalescer_checker #(
  .CNT_W(irq_coal_pkg::THR_W),
  .DLY_W(irq_coal_pkg::DLY_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_word (cfg_word),
  .rx_done  (rx_done),
  .tx_done  (tx_done),
  .ack      (ack),
  .irq      (irq),
  .cnt      (evt_count),
  .tmr      (timer_val)
);

// File: tb/irq_coalescer_bench.sv
module irq_coalescer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [3:0]  rx_done = '0;
  logic [3:0]  tx_done = '0;
  logic        tick = 1'b0;
  logic        ack = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int m_cnt = 0;
  int m_tmr = 0;
  bit m_irq = 1'b0;

  always #2 clk = ~clk;

  irq_coalescer u_irq_coalescer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .rx_done  (rx_done),
    .tx_done  (tx_done),
    .tick     (tick),
    .ack      (ack),
    .irq      (irq)
  );

  function automatic logic [31:0] mk_cfg(input logic [3:0] rxm, input logic [3:0] txm,
                                         input int thr, input int dly);
    logic [31:0] w;
    w = '0;
    w[31:28] = rxm;
    w[27:24] = txm;
    w[20:16] = thr[4:0];
    w[10:0]  = dly[10:0];
    return w;
  endfunction

  // Reference behaviour from the requirements, one clock edge.
  task automatic model_edge();
    int thr, dly, hits, nc, nt;
    bit pend, fire;
    thr = int'(cfg_word[20:16]);
    dly = int'(cfg_word[10:0]);
    if (m_irq) begin
      if (ack) m_irq = 1'b0;
    end else begin
      hits = $countones({rx_done & cfg_word[31:28], tx_done & cfg_word[27:24]});
      nc   = (m_cnt + hits > 31) ? 31 : m_cnt + hits;
      pend = (m_cnt != 0);
      nt   = (pend && tick && m_tmr < 2047) ? m_tmr + 1 : m_tmr;
      fire = (thr != 0 && nc >= thr) || (dly != 0 && pend && tick && nt >= dly);
      if (fire) begin
        m_irq = 1'b1; m_cnt = 0; m_tmr = 0;
      end else begin
        m_cnt = nc; m_tmr = nt;
      end
    end
  endtask

  task automatic check(input string req, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at negedge, clock once, compare with the model at the next negedge.
  task automatic step(input string req, input logic [3:0] rx, input logic [3:0] tx,
                      input logic tk, input logic ak);
    rx_done = rx; tx_done = tx; tick = tk; ack = ak;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, irq, m_irq);
  endtask

  task automatic idle(input string req);
    step(req, 4'h0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic do_ack(input string req);
    step(req, 4'h0, 4'h0, 1'b0, 1'b1);
    check(req, irq, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h1c0a1e5d));
    repeat (3) @(negedge clk);
    check("R1", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", irq, 1'b0);

    // R1: reset cleared count, so two events under threshold 3 do not fire
    cfg_word = mk_cfg(4'hF, 4'hF, 3, 0);
    step("R1", 4'h1, 4'h0, 1'b0, 1'b0); check("R1", irq, 1'b0);
    step("R4", 4'h0, 4'h2, 1'b0, 1'b0); check("R4", irq, 1'b0);
    step("R4", 4'h0, 4'h8, 1'b0, 1'b0); check("R4", irq, 1'b1);
    // R6: held without acknowledge
    idle("R6"); idle("R6"); check("R6", irq, 1'b1);
    do_ack("R6");

    // R3: eight strobes in one cycle reach threshold 5 at once
    cfg_word = mk_cfg(4'hF, 4'hF, 5, 0);
    step("R3", 4'hF, 4'hF, 1'b0, 1'b0); check("R3", irq, 1'b1);
    do_ack("R3");

    // R2: only receive ring 2 (cfg bit 30) enabled
    cfg_word = mk_cfg(4'h4, 4'h0, 1, 0);
    step("R2", 4'hB, 4'hF, 1'b0, 1'b0); check("R2", irq, 1'b0);
    step("R2", 4'hB, 4'hF, 1'b0, 1'b0); check("R2", irq, 1'b0);
    step("R2", 4'h4, 4'h0, 1'b0, 1'b0); check("R2", irq, 1'b1);
    do_ack("R2");

    // R5: delay 3, tick in the first-event cycle does not count
    cfg_word = mk_cfg(4'hF, 4'hF, 0, 3);
    step("R5", 4'h1, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b0);
    step("R5", 4'h0, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b0);
    idle("R5");
    step("R5", 4'h0, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b0);
    step("R5", 4'h0, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b1);
    do_ack("R5");
    // R5: ticks with nothing pending do not advance the timer
    for (int i = 0; i < 6; i++) step("R5", 4'h0, 4'h0, 1'b1, 1'b0);
    step("R5", 4'h0, 4'h1, 1'b0, 1'b0); check("R5", irq, 1'b0);
    step("R5", 4'h0, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b0);
    step("R5", 4'h0, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b0);
    step("R5", 4'h0, 4'h0, 1'b1, 1'b0); check("R5", irq, 1'b1);
    do_ack("R5");

    // R4 and R5 disabled by zero: forty events and many ticks, no fire
    cfg_word = mk_cfg(4'hF, 4'hF, 0, 0);
    for (int i = 0; i < 5; i++) step("R4", 4'hF, 4'hF, 1'b1, 1'b0);
    check("R4", irq, 1'b0);
    check("R5", irq, 1'b0);
    // R3 saturation at 31 with R8 live threshold: raise to 31 and fire
    cfg_word = mk_cfg(4'hF, 4'hF, 31, 0);
    idle("R8"); check("R3", irq, 1'b1);
    do_ack("R8");

    // R7: strobes during irq ignored; ack while low keeps count
    cfg_word = mk_cfg(4'hF, 4'hF, 2, 0);
    step("R7", 4'h3, 4'h0, 1'b0, 1'b0); check("R7", irq, 1'b1);
    step("R7", 4'hF, 4'hF, 1'b1, 1'b0);
    step("R7", 4'hF, 4'hF, 1'b1, 1'b1); check("R7", irq, 1'b0);
    step("R7", 4'h0, 4'h1, 1'b0, 1'b0); check("R7", irq, 1'b0);
    step("R7", 4'h0, 4'h0, 1'b0, 1'b1); check("R7", irq, 1'b0);
    step("R7", 4'h0, 4'h1, 1'b0, 1'b0); check("R7", irq, 1'b1);
    do_ack("R7");

    // R8: lowering threshold onto a held count fires next edge
    cfg_word = mk_cfg(4'hF, 4'hF, 10, 0);
    step("R8", 4'h7, 4'h0, 1'b0, 1'b0); check("R8", irq, 1'b0);
    cfg_word = mk_cfg(4'hF, 4'hF, 3, 0);
    idle("R8"); check("R8", irq, 1'b1);
    do_ack("R8");

    // Random traffic checked cycle by cycle against the model (R2..R8)
    for (int blk = 0; blk < 20; blk++) begin
      cfg_word = mk_cfg(4'($urandom), 4'($urandom),
                        int'($urandom_range(0, 31)), int'($urandom_range(0, 40)));
      for (int i = 0; i < 250; i++) begin
        logic [3:0] rx, tx;
        rx = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
        tx = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
        step("R2-model", rx, tx, ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 7) == 0));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule